// File: doc/BRIEF.md
# Polarity-Configurable Set/Reset Storage Cell

This block stores one bit. Parameters fixed at elaboration decide how it stores that bit. It can be an edge-triggered flip-flop, or a level-sensitive latch whose clock pin serves as the transparency gate. Two force inputs pin the stored value. The primary force drives the cell to a parameter-chosen target value. The reverse force drives it to the complement of that target. When both are active, the low result wins. The forces act either on the cell's timing event (the active clock edge, or the open gate) or at once, independent of the clock.

The clock, clock-enable, primary-force and reverse-force pins each carry an inversion parameter, so no external inverters are needed. The clock enable can be declared unused, and the cell then behaves as always enabled. The power-up value is a parameter of its own. By default it equals the force target, and it can be overridden. A wider design places one instance wherever it needs a configurable storage bit.

Top module: `srcell_top`

## Requirements
- R1: In flip-flop mode (`CELL_KIND` = `KIND_FLOP`) with no force active, the output takes the data input on each active clock edge where the enable is active. Between active edges it does not change.
- R2: In latch mode (`CELL_KIND` = `KIND_LATCH`) with no force active, the output follows the data input while the gate is at its active level and the enable is active. While the gate is at its inactive level, the output holds.
- R3: Each control pin is active when its raw level XOR its inversion parameter (`CLK_INV`, `CE_INV`, `SR_INV`, `REV_INV`) equals 1. With `CLK_INV`=1, the falling edge is the active edge and a low gate is the open gate.
- R4: With the enable inactive, the cell ignores the data input and holds. With `CE_USED`=0, the level on the enable pin is ignored and the cell acts as permanently enabled.
- R5: The primary force alone drives the output to `SR_TARGET`. The reverse force alone drives it to the complement of `SR_TARGET`.
- R6: When both forces are active together, the output is driven to 0, whatever `SR_TARGET` is.
- R7: With `SR_APPLY` = `APPLY_SYNC`, a force takes effect only on an active clock edge (flip-flop) or while the gate is open (latch). It takes effect even when the enable is inactive.
- R8: With `SR_APPLY` = `APPLY_ASYNC`, a force changes the output at once without any clock activity. After the force is released, the output holds its forced value until the cell's normal capture (edge or open gate, with enable) occurs.
- R9: Before any clock activity or force, the output equals `INIT_VAL`. `INIT_VAL` defaults to `SR_TARGET` and can be set to the opposite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (flip-flop mode) or transparency gate (latch mode), polarity set by `CLK_INV` |
| ce_i | input | 1 | Clock enable, polarity set by `CE_INV`, ignored when `CE_USED`=0 |
| sr_i | input | 1 | Primary force toward `SR_TARGET`, polarity set by `SR_INV` |
| rev_i | input | 1 | Reverse force toward the complement of `SR_TARGET`, polarity set by `REV_INV` |
| d_i | input | 1 | Data input |
| q_o | output | 1 | Stored value |

## Verification
Eight instances run side by side. Together they cover every pairing of storage kind, force timing and force target, and they mix the inversion settings, the enable-unused option and the overridden power-up value. Directed patterns come first. Alternating data with enable held active separates edge capture from transparent following. Random data with enable inactive shows whether data leaks through. The primary force, the reverse force and both together are each applied with enable inactive, which shows whether a force waits for the clock event and whether the low result wins. A release is followed by idle cycles, which shows that the forced value is held until normal capture resumes. A long random phase then mixes rare forces with random enable and data. Each phase is sampled right after the inputs change and after both clock edges, so immediate and edge-timed actions are told apart.

// File: rtl/srcell_pkg.sv
package srcell_pkg;

    typedef enum logic {
        KIND_FLOP  = 1'b0,
        KIND_LATCH = 1'b1
    } cell_kind_e;

    typedef enum logic {
        APPLY_SYNC  = 1'b0,
        APPLY_ASYNC = 1'b1
    } apply_mode_e;

    // Control pins after polarity normalisation (all active high).
    typedef struct packed {
        logic aclk;
        logic en;
        logic sr;
        logic rev;
        logic d;
    } ctl_t;

    // Resolved force: at most one of lo/hi is set.
    typedef struct packed {
        logic lo;
        logic hi;
    } force_t;

    function automatic logic to_active(logic raw, bit inv);
        return raw ^ inv;
    endfunction

    // Low result dominates when both forces are present.
    function automatic force_t resolve_force(logic sr, logic rev, bit target);
        force_t f;
        logic   want_hi;
        logic   want_lo;
        want_hi = (sr && target) || (rev && !target);
        want_lo = (sr && !target) || (rev && target);
        f.lo = want_lo;
        f.hi = want_hi && !want_lo;
        return f;
    endfunction

endpackage

// File: rtl/srcell_pins.sv
module srcell_pins
    import srcell_pkg::*;
#(
    parameter bit CLK_INV = 1'b0,
    parameter bit CE_INV  = 1'b0,
    parameter bit SR_INV  = 1'b0,
    parameter bit REV_INV = 1'b0,
    parameter bit CE_USED = 1'b1
) (
    input  logic clk_i,
    input  logic ce_i,
    input  logic sr_i,
    input  logic rev_i,
    input  logic d_i,
    output ctl_t ctl_o
);

    logic ce_act;

    assign ce_act = to_active(ce_i, CE_INV);

    always_comb begin
        ctl_o.aclk = to_active(clk_i, CLK_INV);
        ctl_o.en   = CE_USED ? ce_act : 1'b1;
        ctl_o.sr   = to_active(sr_i, SR_INV);
        ctl_o.rev  = to_active(rev_i, REV_INV);
        ctl_o.d    = d_i;
    end

endmodule

// File: rtl/srcell_force.sv
module srcell_force
    import srcell_pkg::*;
#(
    parameter bit SR_TARGET = 1'b0
) (
    input  ctl_t   ctl_i,
    output force_t frc_o
);

    assign frc_o = resolve_force(ctl_i.sr, ctl_i.rev, SR_TARGET);

endmodule

// File: rtl/srcell_store.sv
module srcell_store
    import srcell_pkg::*;
#(
    parameter cell_kind_e  CELL_KIND = KIND_FLOP,
    parameter apply_mode_e SR_APPLY  = APPLY_SYNC,
    parameter bit          INIT_VAL  = 1'b0
) (
    input  ctl_t   ctl_i,
    input  force_t frc_i,
    output logic   q_o
);

    logic aclk;
    logic en;
    logic d;
    logic f_lo;
    logic f_hi;
    logic state_q = INIT_VAL;

    assign aclk = ctl_i.aclk;
    assign en   = ctl_i.en;
    assign d    = ctl_i.d;
    assign f_lo = frc_i.lo;
    assign f_hi = frc_i.hi;

    generate
        if (CELL_KIND == KIND_FLOP && SR_APPLY == APPLY_ASYNC) begin : g_flop_async
            always_ff @(posedge aclk or posedge f_lo or posedge f_hi) begin
                if (f_lo)      state_q <= 1'b0;
                else if (f_hi) state_q <= 1'b1;
                else if (en)   state_q <= d;
            end
        end else if (CELL_KIND == KIND_FLOP) begin : g_flop_sync
            always_ff @(posedge aclk) begin
                if (f_lo)      state_q <= 1'b0;
                else if (f_hi) state_q <= 1'b1;
                else if (en)   state_q <= d;
            end
        end else if (SR_APPLY == APPLY_ASYNC) begin : g_latch_async
            always_latch begin
                if (f_lo)          state_q = 1'b0;
                else if (f_hi)     state_q = 1'b1;
                else if (aclk && en) state_q = d;
            end
        end else begin : g_latch_sync
            always_latch begin
                if (aclk) begin
                    if (f_lo)      state_q = 1'b0;
                    else if (f_hi) state_q = 1'b1;
                    else if (en)   state_q = d;
                end
            end
        end
    endgenerate

    assign q_o = state_q;

endmodule

// File: rtl/srcell_top.sv
module srcell_top
    import srcell_pkg::*;
#(
    parameter cell_kind_e  CELL_KIND = KIND_FLOP,
    parameter apply_mode_e SR_APPLY  = APPLY_SYNC,
    parameter bit          SR_TARGET = 1'b0,
    parameter bit          INIT_VAL  = SR_TARGET,
    parameter bit          CLK_INV   = 1'b0,
    parameter bit          CE_INV    = 1'b0,
    parameter bit          SR_INV    = 1'b0,
    parameter bit          REV_INV   = 1'b0,
    parameter bit          CE_USED   = 1'b1
) (
    input  logic clk_i,
    input  logic ce_i,
    input  logic sr_i,
    input  logic rev_i,
    input  logic d_i,
    output logic q_o
);

    ctl_t   ctl;
    force_t frc;

    srcell_pins #(
        .CLK_INV (CLK_INV),
        .CE_INV  (CE_INV),
        .SR_INV  (SR_INV),
        .REV_INV (REV_INV),
        .CE_USED (CE_USED)
    ) u_pins (
        .clk_i (clk_i),
        .ce_i  (ce_i),
        .sr_i  (sr_i),
        .rev_i (rev_i),
        .d_i   (d_i),
        .ctl_o (ctl)
    );

    srcell_force #(
        .SR_TARGET (SR_TARGET)
    ) u_force (
        .ctl_i (ctl),
        .frc_o (frc)
    );

    srcell_store #(
        .CELL_KIND (CELL_KIND),
        .SR_APPLY  (SR_APPLY),
        .INIT_VAL  (INIT_VAL)
    ) u_store (
        .ctl_i (ctl),
        .frc_i (frc),
        .q_o   (q_o)
    );

endmodule

// File: rtl/srcell_chk.sv
module srcell_chk
    import srcell_pkg::*;
#(
    parameter cell_kind_e  CELL_KIND = KIND_FLOP,
    parameter apply_mode_e SR_APPLY  = APPLY_SYNC,
    parameter bit          SR_TARGET = 1'b0,
    parameter bit          CLK_INV   = 1'b0,
    parameter bit          CE_INV    = 1'b0,
    parameter bit          SR_INV    = 1'b0,
    parameter bit          REV_INV   = 1'b0,
    parameter bit          CE_USED   = 1'b1
) (
    input logic clk_i,
    input logic ce_i,
    input logic sr_i,
    input logic rev_i,
    input logic d_i,
    input logic q_o
);

    localparam bit IS_SFLOP  = (CELL_KIND == KIND_FLOP) && (SR_APPLY == APPLY_SYNC);
    localparam bit IS_LATCH  = (CELL_KIND == KIND_LATCH);
    localparam bit IS_SLATCH = IS_LATCH && (SR_APPLY == APPLY_SYNC);
    localparam bit IS_ASYNC  = (SR_APPLY == APPLY_ASYNC);

    logic aclk;
    logic en;
    logic sr_a;
    logic rev_a;
    logic hit;
    logic goal;
    logic armed = 1'b0;

    assign aclk  = clk_i ^ CLK_INV;
    assign en    = CE_USED ? (ce_i ^ CE_INV) : 1'b1;
    assign sr_a  = sr_i ^ SR_INV;
    assign rev_a = rev_i ^ REV_INV;
    assign hit   = sr_a || rev_a;
    assign goal  = (sr_a && rev_a) ? 1'b0 : (sr_a ? SR_TARGET : !SR_TARGET);

    always_ff @(posedge aclk) armed <= 1'b1;

    assert_capture_R1: assert property (@(posedge aclk) disable iff (!armed)
        (IS_SFLOP && !hit && en) |=> (q_o == $past(d_i)));

    assert_hold_R4: assert property (@(posedge aclk) disable iff (!armed)
        (IS_SFLOP && !hit && !en) |=> $stable(q_o));

    assert_sync_force_R7: assert property (@(posedge aclk) disable iff (!armed)
        (IS_SFLOP && hit) |=> (q_o == $past(goal)));

    assert_low_wins_R6: assert property (@(posedge aclk) disable iff (!armed)
        (IS_SFLOP && sr_a && rev_a) |=> !q_o);

    assert_transparent_R2: assert property (@(negedge aclk) disable iff (!armed)
        (IS_LATCH && !hit && en) |-> (q_o == d_i));

    assert_latch_force_R7: assert property (@(negedge aclk) disable iff (!armed)
        (IS_SLATCH && hit) |-> (q_o == goal));

    assert_async_force_R8: assert property (@(negedge aclk) disable iff (!armed)
        (IS_ASYNC && hit) |-> (q_o == goal));

endmodule

bind srcell_top srcell_chk #(
    .CELL_KIND (CELL_KIND),
    .SR_APPLY  (SR_APPLY),
    .SR_TARGET (SR_TARGET),
    .CLK_INV   (CLK_INV),
    .CE_INV    (CE_INV),
    .SR_INV    (SR_INV),
    .REV_INV   (REV_INV),
    .CE_USED   (CE_USED)
) u_chk (
    .clk_i (clk_i),
    .ce_i  (ce_i),
    .sr_i  (sr_i),
    .rev_i (rev_i),
    .d_i   (d_i),
    .q_o   (q_o)
);

// File: tb/test_srcell_top.sv
`timescale 1ns/100ps
module test_srcell_top;
    import srcell_pkg::*;

    // Instance g: bit0 = latch, bit1 = async, bit2 = target.
    localparam logic [7:0] LAT  = 8'b1010_1010;
    localparam logic [7:0] ASY  = 8'b1100_1100;
    localparam logic [7:0] TGT  = 8'b1111_0000;
    localparam logic [7:0] CLKI = 8'b0101_1010;
    localparam logic [7:0] CEI  = 8'b1100_1100;
    localparam logic [7:0] SRI  = 8'b0110_0110;
    localparam logic [7:0] REVI = 8'b0011_1100;
    localparam logic [7:0] OVR  = 8'b0100_1000;
    localparam logic [7:0] INIT = TGT ^ OVR;
    localparam logic [7:0] CEU  = 8'b1101_1111;

    typedef struct {
        logic [7:0] q;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic [7:0] d_raw = '0, ce_raw = '0, sr_raw = '0, rev_raw = '0;
    logic [7:0] q_v;
    logic [7:0] mdl = INIT;
    logic [7:0] a_d, a_ce, a_sr, a_rev;
    sb_item_t   sb[$];
    event       sample_ev;
    int         compared = 0;
    int         mismatched = 0;
    bit         done = 1'b0;

    for (genvar g = 0; g < 8; g++) begin : g_cell
        if (OVR[g]) begin : g_ovr
            srcell_top #(
                .CELL_KIND (LAT[g] ? KIND_LATCH : KIND_FLOP),
                .SR_APPLY  (ASY[g] ? APPLY_ASYNC : APPLY_SYNC),
                .SR_TARGET (TGT[g]), .INIT_VAL (INIT[g]),
                .CLK_INV (CLKI[g]), .CE_INV (CEI[g]), .SR_INV (SRI[g]),
                .REV_INV (REVI[g]), .CE_USED (CEU[g])
            ) i_srcell_top (
                .clk_i (clk), .ce_i (ce_raw[g]), .sr_i (sr_raw[g]),
                .rev_i (rev_raw[g]), .d_i (d_raw[g]), .q_o (q_v[g])
            );
        end else begin : g_dflt
            srcell_top #(
                .CELL_KIND (LAT[g] ? KIND_LATCH : KIND_FLOP),
                .SR_APPLY  (ASY[g] ? APPLY_ASYNC : APPLY_SYNC),
                .SR_TARGET (TGT[g]),
                .CLK_INV (CLKI[g]), .CE_INV (CEI[g]), .SR_INV (SRI[g]),
                .REV_INV (REVI[g]), .CE_USED (CEU[g])
            ) i_srcell_top (
                .clk_i (clk), .ce_i (ce_raw[g]), .sr_i (sr_raw[g]),
                .rev_i (rev_raw[g]), .d_i (d_raw[g]), .q_o (q_v[g])
            );
        end
    end

    // Behavioural reference built from the requirements.
    function automatic logic ref_next(int i, logic m, logic lvl, logic rise, logic fall);
        logic hit, fv, en, act_edge, open;
        hit      = a_sr[i] || a_rev[i];
        fv       = (a_sr[i] && a_rev[i]) ? 1'b0 : (a_sr[i] ? TGT[i] : !TGT[i]);
        en       = CEU[i] ? a_ce[i] : 1'b1;
        act_edge = CLKI[i] ? fall : rise;
        open     = lvl ^ CLKI[i];
        if (ASY[i] && hit) return fv;
        if (LAT[i]) return open ? (hit ? fv : (en ? a_d[i] : m)) : m;
        if (act_edge) return hit ? fv : (en ? a_d[i] : m);
        return m;
    endfunction

    task automatic push(input string tag);
        sb_item_t it;
        it.q   = mdl;
        it.tag = tag;
        sb.push_back(it);
        -> sample_ev;
    endtask

    task automatic eval_all(input logic lvl, input logic rise, input logic fall);
        for (int i = 0; i < 8; i++) mdl[i] = ref_next(i, mdl[i], lvl, rise, fall);
    endtask

    // One 4 ns clock period, three sample points.
    task automatic step(input logic [7:0] d, input logic [7:0] ce,
                        input logic [7:0] sr, input logic [7:0] rev, input string tag);
        #0.5;
        a_d = d; a_ce = ce; a_sr = sr; a_rev = rev;
        d_raw = d; ce_raw = ce ^ CEI; sr_raw = sr ^ SRI; rev_raw = rev ^ REVI;
        eval_all(1'b0, 1'b0, 1'b0);
        #0.5 push(tag);
        #0.5 clk = 1'b1;
        eval_all(1'b1, 1'b1, 1'b0);
        #1   push(tag);
        #1   clk = 1'b0;
        eval_all(1'b0, 1'b0, 1'b1);
        #0.5 push(tag);
    endtask

    function automatic logic [7:0] rnd8();
        return 8'($urandom);
    endfunction

    function automatic logic [7:0] rare8();
        return rnd8() & rnd8() & rnd8();
    endfunction

    // Monitor: pops the scoreboard and compares every instance.
    initial begin
        forever begin
            sb_item_t it;
            @(sample_ev);
            it = sb.pop_front();
            for (int i = 0; i < 8; i++) begin
                compared++;
                if (q_v[i] !== it.q[i]) begin
                    mismatched++;
                    $display("FAIL %s cell %0d t=%0t actual=%b expected=%b",
                             it.tag, i, $time, q_v[i], it.q[i]);
                end
            end
        end
    end

    // Driver
    initial begin
        a_d = ~INIT; a_ce = '0; a_sr = '0; a_rev = '0;
        d_raw = ~INIT; ce_raw = CEI; sr_raw = SRI; rev_raw = REVI;
        #0.2 push("R9 power-up value");
        // R1 R2 R3: alternating data, enable active
        for (int k = 0; k < 6; k++)
            step((k % 2) ? 8'h55 : 8'hAA, 8'hFF, 8'h00, 8'h00, "R1 R2 R3 capture");
        // R4: enable inactive, data random
        for (int k = 0; k < 5; k++)
            step(rnd8(), 8'h00, 8'h00, 8'h00, "R4 enable off");
        // R5 R7: primary force with enable off
        for (int k = 0; k < 3; k++)
            step(rnd8(), 8'h00, 8'hFF, 8'h00, "R5 R7 primary force");
        // R8: release and hold
        for (int k = 0; k < 2; k++)
            step(rnd8(), 8'h00, 8'h00, 8'h00, "R8 hold after release");
        step(~mdl, 8'hFF, 8'h00, 8'h00, "R8 resume capture");
        // R5: reverse force
        for (int k = 0; k < 3; k++)
            step(rnd8(), 8'h00, 8'h00, 8'hFF, "R5 R7 reverse force");
        step(8'hFF, 8'hFF, 8'h00, 8'h00, "R1 R2 load ones");
        // R6: both forces
        for (int k = 0; k < 3; k++)
            step(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 low wins");
        step(8'hFF, 8'h00, 8'hFF, 8'h00, "R6 R8 drop reverse");
        // Random mix
        for (int k = 0; k < 1500; k++)
            step(rnd8(), rnd8(), rare8(), rare8(), "R1 R2 R3 R4 R5 R6 R7 R8 random");
        #1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule